// File: doc/BRIEF.md
# Precise Pipeline Exception Controller

This block tracks the five instructions in flight in an in-order integer pipeline (fetch, decode, execute, memory, writeback) and decides when control leaves the program. Each stage can flag a fault against the instruction it holds. The fault code is stored in the pipeline latch next to that instruction and travels with it. The code is only acted on when the instruction reaches writeback, which is the single commit point. Because faults are acted on there, they are handled strictly in program order. An older memory fault therefore wins over a younger decode fault, even when the decode fault was raised first in time.

When a faulting instruction reaches the commit point, the block does the following. It drops that instruction and everything younger, emits a one-cycle flush, and stores the instruction's PC and its code. It then points fetch at a fixed handler address and enters privileged mode. An external interrupt is handled the same way. It is attached to a clean instruction in the execute stage, so every older instruction completes and the interrupted one is the first to be replayed. A return instruction that commits sends fetch back to the saved PC and leaves privileged mode, so the faulting instruction gets a second try.

The datapath, ALU, memory and translation logic are not part of this block. Its fault inputs are driven by those units, and its `me_mem_en` and `commit_valid` outputs gate their side effects.

Top module: `pexc_ctrl`

## Requirements
- R1: After reset, `fetch_pc` equals RESET_PC (default 0x1000), and `fetch_valid`, `priv_mode`, `flush`, `commit_valid`, `epc` and `cause` are all zero.
- R2: With no faults, `fetch_pc` advances by INSN_STEP (default 4) every cycle once `fetch_valid` is high. An instruction that is in fetch in cycle n commits in cycle n+4, with `commit_valid` high and `commit_pc` equal to its PC, in program order.
- R3: A fault is recorded with a code set by the stage that raised it: fetch 0x21, decode 0x22, execute 0x23, memory 0x24 (6-bit codes).
- R4: When a faulting instruction is in writeback, `flush` is high and `commit_valid` is low in that cycle. In the next cycle `fetch_pc` equals HANDLER_PC (default 0xbfc00200), `priv_mode` is 1, `epc` holds the faulting instruction's PC and `cause` holds its code.
- R5: Faults are serviced in program order. An older instruction that faults in memory is taken ahead of a younger instruction that faulted in decode one cycle earlier.
- R6: Instructions older than a faulting one commit normally. Instructions younger than it never commit, and `me_mem_en` is low while any of them is in the memory stage.
- R7: A non-zero external interrupt code is accepted only when all of these hold: not in privileged mode, a valid fault-free instruction in execute, no faulting instruction in memory, and no flush. It is attached to the execute instruction, so its `me_mem_en` is low. `cause` becomes the interrupt code with the top bit set, and `epc` becomes that instruction's PC.
- R8: An interrupt request is ignored while in privileged mode, and ignored in a cycle where an older instruction in memory faults. In that case the memory fault's code is what gets recorded.
- R9: A return instruction, flagged by `id_eret` while it is in decode, commits in writeback with `flush` high. In the next cycle `fetch_pc` equals `epc` and `priv_mode` is 0, and the replayed instruction later commits at the same PC.
- R10: Every non-zero `cause` value has its top bit set; stage codes without it are rejected at elaboration.
- R11: `flush` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_fault | input | 1 | Fetch of the instruction in the fetch stage failed |
| id_fault | input | 1 | Instruction in decode has an illegal opcode |
| id_eret | input | 1 | Instruction in decode is a return from exception |
| ex_fault | input | 1 | Instruction in execute raised an arithmetic fault |
| me_fault | input | 1 | Memory access of the instruction in the memory stage failed |
| irq_code | input | CW-1 | External interrupt code, zero when no request |
| fetch_pc | output | AW | PC of the instruction in the fetch stage |
| fetch_valid | output | 1 | Fetch stage holds a live instruction |
| me_mem_en | output | 1 | Memory stage instruction may perform its access |
| commit_valid | output | 1 | Writeback instruction retires (register write allowed) |
| commit_pc | output | AW | PC of the writeback instruction |
| flush | output | 1 | Redirect at the commit point, all younger stages cleared |
| priv_mode | output | 1 | Privileged mode |
| epc | output | AW | Saved PC of the instruction to resume at |
| cause | output | CW | Saved code of the last exception or interrupt |

## Verification
Two events can land in one cycle. The first is an older instruction faulting in memory while an interrupt request arrives for the clean instruction behind it in execute. The bench raises both in the same cycle. It requires that the interrupt be dropped, that the memory code and load PC be saved, and that the load's successor never retire. The second overlap is two faults in flight at once. A younger decode fault is raised one cycle before an older memory fault. The recorded cause and saved PC show which fault reached the commit point first.

// File: rtl/pexc_pkg.sv
package pexc_pkg;
   // Pipeline stage positions; higher index is older.
   typedef enum logic [2:0] {
      STG_FE = 3'd0,
      STG_DE = 3'd1,
      STG_EX = 3'd2,
      STG_MM = 3'd3,
      STG_WB = 3'd4
   } stage_e;

   localparam int NUM_STAGES = 5;

   // True when a stage code marks a fault (top bit set, rest arbitrary).
   function automatic logic code_is_fault(input logic msb);
      return msb;
   endfunction
endpackage

// File: rtl/pexc_pc_unit.sv
module pexc_pc_unit #(
   parameter int          AW        = 32,
   parameter logic [AW-1:0] RESET_PC  = 32'h0000_1000,
   parameter int          INSN_STEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          redirect,
   input  logic [AW-1:0] redirect_pc,
   output logic [AW-1:0] fetch_pc,
   output logic          fetch_valid
);
   localparam logic [AW-1:0] STEP = AW'(INSN_STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_pc    <= RESET_PC;
         fetch_valid <= 1'b0;
      end else if (redirect) begin
         fetch_pc    <= redirect_pc;
         fetch_valid <= 1'b1;
      end else begin
         if (fetch_valid) fetch_pc <= fetch_pc + STEP;
         fetch_valid <= 1'b1;
      end
   end
endmodule

// File: rtl/pexc_stage_latch.sv
module pexc_stage_latch #(
   parameter int AW = 32,
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          kill,
   input  logic          in_valid,
   input  logic [AW-1:0] in_pc,
   input  logic [CW-1:0] in_code,
   input  logic          in_eret,
   output logic          q_valid,
   output logic [AW-1:0] q_pc,
   output logic [CW-1:0] q_code,
   output logic          q_eret
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_pc    <= '0;
         q_code  <= '0;
         q_eret  <= 1'b0;
      end else begin
         q_valid <= in_valid & ~kill;
         q_pc    <= in_pc;
         q_code  <= (kill || !in_valid) ? '0 : in_code;
         q_eret  <= in_valid & ~kill & in_eret;
      end
   end
endmodule

// File: rtl/pexc_commit_unit.sv
module pexc_commit_unit #(
   parameter int            AW         = 32,
   parameter int            CW         = 6,
   parameter logic [AW-1:0] HANDLER_PC = 32'hbfc0_0200
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wb_valid,
   input  logic [AW-1:0] wb_pc,
   input  logic [CW-1:0] wb_code,
   input  logic          wb_eret,
   output logic          take,
   output logic          ret,
   output logic [AW-1:0] redirect_pc,
   output logic [AW-1:0] epc_q,
   output logic [CW-1:0] cause_q,
   output logic          priv_q
);
   logic has_code;

   assign has_code    = pexc_pkg::code_is_fault(wb_code[CW-1]);
   assign take        = wb_valid & has_code;
   assign ret         = wb_valid & wb_eret & ~has_code;
   assign redirect_pc = take ? HANDLER_PC : epc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q   <= '0;
         cause_q <= '0;
         priv_q  <= 1'b0;
      end else if (take) begin
         epc_q   <= wb_pc;
         cause_q <= wb_code;
         priv_q  <= 1'b1;
      end else if (ret) begin
         priv_q  <= 1'b0;
      end
   end
endmodule

// File: rtl/pexc_ctrl.sv
module pexc_ctrl #(
   parameter int            AW         = 32,
   parameter int            CW         = 6,
   parameter int            INSN_STEP  = 4,
   parameter logic [AW-1:0] RESET_PC   = 32'h0000_1000,
   parameter logic [AW-1:0] HANDLER_PC = 32'hbfc0_0200,
   parameter logic [CW-1:0] CODE_FE    = 6'h21,
   parameter logic [CW-1:0] CODE_DE    = 6'h22,
   parameter logic [CW-1:0] CODE_EX    = 6'h23,
   parameter logic [CW-1:0] CODE_MM    = 6'h24,
   parameter bit            IRQ_ENABLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            if_fault,
   input  logic            id_fault,
   input  logic            id_eret,
   input  logic            ex_fault,
   input  logic            me_fault,
   input  logic [CW-2:0]   irq_code,
   output logic [AW-1:0]   fetch_pc,
   output logic            fetch_valid,
   output logic            me_mem_en,
   output logic            commit_valid,
   output logic [AW-1:0]   commit_pc,
   output logic            flush,
   output logic            priv_mode,
   output logic [AW-1:0]   epc,
   output logic [CW-1:0]   cause
);
   import pexc_pkg::*;

   localparam int NS   = NUM_STAGES;
   localparam int NDET = NS - 1;
   localparam int EXI  = int'(STG_EX);
   localparam int MMI  = int'(STG_MM);
   localparam int WBI  = int'(STG_WB);

   // Elaboration-time parameter checks
   if (CW < 2) begin : g_bad_cw
      $error("pexc_ctrl: CW must be at least 2");
   end
   if (INSN_STEP < 1) begin : g_bad_step
      $error("pexc_ctrl: INSN_STEP must be positive");
   end
   if (!(CODE_FE[CW-1] && CODE_DE[CW-1] && CODE_EX[CW-1] && CODE_MM[CW-1])) begin : g_bad_code
      $error("pexc_ctrl: every stage fault code needs its top bit set");
   end

   // Per-stage state, index 0 = fetch, 4 = writeback
   logic [NS-1:0]   sv;
   logic [AW-1:0]   spc   [NS];
   logic [CW-1:0]   scode [NS];
   logic [NS-1:0]   ser;

   // Per-stage view after local detection (stages 0..3)
   logic [CW-1:0]   code_n [NDET];
   logic [NDET-1:0] er_n;
   logic [NDET-1:0] hot;
   logic [NDET-1:0] older;
   logic [NDET-1:0] fault_in;
   logic [CW-1:0]   stage_code [NDET];

   logic            take, ret, irq_acc;
   logic [AW-1:0]   redirect_pc;
   logic [CW-1:0]   irq_cause;

   assign fault_in   = {me_fault, ex_fault, id_fault, if_fault};
   assign stage_code[0] = CODE_FE;
   assign stage_code[1] = CODE_DE;
   assign stage_code[2] = CODE_EX;
   assign stage_code[3] = CODE_MM;
   assign irq_cause  = {1'b1, irq_code};
   assign flush      = take | ret;

   pexc_pc_unit #(
      .AW(AW), .RESET_PC(RESET_PC), .INSN_STEP(INSN_STEP)
   ) u_pc (
      .clk(clk), .rst_n(rst_n),
      .redirect(flush), .redirect_pc(redirect_pc),
      .fetch_pc(fetch_pc), .fetch_valid(fetch_valid)
   );

   assign sv[0]    = fetch_valid;
   assign spc[0]   = fetch_pc;
   assign scode[0] = '0;
   assign ser[0]   = 1'b0;

   // Interrupt acceptance variant
   if (IRQ_ENABLE) begin : g_irq
      assign irq_acc = (|irq_code) & ~priv_mode & sv[EXI] & ~scode[EXI][CW-1]
                       & ~ex_fault & ~hot[MMI] & ~flush;
   end else begin : g_no_irq
      assign irq_acc = 1'b0;
   end

   for (genvar k = 0; k < NDET; k++) begin : g_stage
      // Local fault detection: an inherited code wins over a new one
      if (k == EXI) begin : g_det_ex
         assign code_n[k] = scode[k][CW-1]            ? scode[k]      :
                            (sv[k] && fault_in[k])    ? stage_code[k] :
                            irq_acc                   ? irq_cause     : '0;
      end else begin : g_det
         assign code_n[k] = scode[k][CW-1]            ? scode[k]      :
                            (sv[k] && fault_in[k])    ? stage_code[k] : '0;
      end

      if (k == int'(STG_DE)) begin : g_eret
         assign er_n[k] = ser[k] | id_eret;
      end else begin : g_no_eret
         assign er_n[k] = ser[k];
      end

      assign hot[k] = sv[k] & code_n[k][CW-1];

      // A faulting stage kills every younger stage on the next advance
      if (k == NDET - 1) begin : g_oldest
         assign older[k] = 1'b0;
      end else begin : g_chain
         assign older[k] = older[k+1] | hot[k+1];
      end

      pexc_stage_latch #(.AW(AW), .CW(CW)) u_latch (
         .clk(clk), .rst_n(rst_n),
         .kill(flush | older[k]),
         .in_valid(sv[k]), .in_pc(spc[k]), .in_code(code_n[k]), .in_eret(er_n[k]),
         .q_valid(sv[k+1]), .q_pc(spc[k+1]), .q_code(scode[k+1]), .q_eret(ser[k+1])
      );
   end

   pexc_commit_unit #(.AW(AW), .CW(CW), .HANDLER_PC(HANDLER_PC)) u_commit (
      .clk(clk), .rst_n(rst_n),
      .wb_valid(sv[WBI]), .wb_pc(spc[WBI]), .wb_code(scode[WBI]), .wb_eret(ser[WBI]),
      .take(take), .ret(ret), .redirect_pc(redirect_pc),
      .epc_q(epc), .cause_q(cause), .priv_q(priv_mode)
   );

   assign me_mem_en    = sv[MMI] & ~scode[MMI][CW-1];
   assign commit_valid = sv[WBI] & ~scode[WBI][CW-1];
   assign commit_pc    = spc[WBI];
endmodule

// File: rtl/pexc_ctrl_chk.sv
module pexc_ctrl_chk #(
   parameter int            AW         = 32,
   parameter int            CW         = 6,
   parameter int            INSN_STEP  = 4,
   parameter logic [AW-1:0] HANDLER_PC = 32'hbfc0_0200
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] fetch_pc,
   input logic          fetch_valid,
   input logic          commit_valid,
   input logic          flush,
   input logic          priv_mode,
   input logic [AW-1:0] epc,
   input logic [CW-1:0] cause
);
   localparam logic [AW-1:0] STEP = AW'(INSN_STEP);

   // R11: one-cycle flush
   p_flush_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !flush);

   // R10: saved codes always carry the top bit
   p_cause_msb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cause != '0) |-> cause[CW-1]);

   // R4: taking a fault lands on the handler in privileged mode
   p_take_handler_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !commit_valid) |=> (priv_mode && fetch_pc == HANDLER_PC));

   // R9: a committed return resumes at the saved PC in user mode
   p_return_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && commit_valid) |=> (!priv_mode && fetch_pc == $past(epc)));

   // R4: saved PC only changes on a take
   p_epc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(flush && !commit_valid) |=> $stable(epc));

   // R2: sequential fetch when no redirect
   p_fetch_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !flush) |=> (fetch_pc == $past(fetch_pc) + STEP));
endmodule

bind pexc_ctrl pexc_ctrl_chk #(
   .AW(AW), .CW(CW), .INSN_STEP(INSN_STEP), .HANDLER_PC(HANDLER_PC)
) u_pexc_chk (
   .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_valid(fetch_valid),
   .commit_valid(commit_valid), .flush(flush), .priv_mode(priv_mode),
   .epc(epc), .cause(cause)
);

// File: tb/pexc_ctrl_bench.sv
module pexc_ctrl_bench;
   localparam int          AW = 32;
   localparam int          CW = 6;
   localparam logic [31:0] RPC = 32'h0000_1000;
   localparam logic [31:0] HPC = 32'hbfc0_0200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          if_fault = 1'b0, id_fault = 1'b0, id_eret = 1'b0;
   logic          ex_fault = 1'b0, me_fault = 1'b0;
   logic [CW-2:0] irq_code = '0;
   logic [AW-1:0] fetch_pc, commit_pc, epc;
   logic          fetch_valid, me_mem_en, commit_valid, flush, priv_mode;
   logic [CW-1:0] cause;

   int checks = 0;
   int errors = 0;
   int st = 0;

   always #5 clk = ~clk;

   pexc_ctrl u_pexc_ctrl (
      .clk(clk), .rst_n(rst_n), .if_fault(if_fault), .id_fault(id_fault),
      .id_eret(id_eret), .ex_fault(ex_fault), .me_fault(me_fault),
      .irq_code(irq_code), .fetch_pc(fetch_pc), .fetch_valid(fetch_valid),
      .me_mem_en(me_mem_en), .commit_valid(commit_valid), .commit_pc(commit_pc),
      .flush(flush), .priv_mode(priv_mode), .epc(epc), .cause(cause)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      if_fault = 0; id_fault = 0; id_eret = 0; ex_fault = 0; me_fault = 0;
      irq_code = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      st = 0;
   endtask

   // Move to state k: k rising edges after reset release, sampled mid-cycle
   task automatic go(input int k);
      while (st < k) begin
         @(posedge clk);
         @(negedge clk);
         st++;
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "fetch_pc", fetch_pc, RPC);
      chk("R1", "fetch_valid", 32'(fetch_valid), 0);
      chk("R1", "priv", 32'(priv_mode), 0);
      chk("R1", "flush", 32'(flush), 0);
      chk("R1", "commit_valid", 32'(commit_valid), 0);
      chk("R1", "epc", epc, 0);
      chk("R1", "cause", 32'(cause), 0);
   endtask

   task automatic t_stream();
      do_reset();
      go(1);
      chk("R2", "first fetch", fetch_pc, RPC);
      go(4);
      chk("R2", "mem enable", 32'(me_mem_en), 1);
      chk("R2", "no commit yet", 32'(commit_valid), 0);
      go(5);
      chk("R2", "first commit", 32'(commit_valid), 1);
      chk("R2", "first commit pc", commit_pc, RPC);
      go(8);
      chk("R2", "fourth commit pc", commit_pc, RPC + 12);
      chk("R2", "fetch pc", fetch_pc, RPC + 28);
   endtask

   // Memory fault on RPC+8, then return and retry
   task automatic t_mem_fault_and_return();
      do_reset();
      go(6);
      chk("R6", "older commits", commit_pc, RPC + 4);
      chk("R6", "older commit valid", 32'(commit_valid), 1);
      me_fault = 1;
      go(7);
      me_fault = 0;
      chk("R4", "flush on take", 32'(flush), 1);
      chk("R4", "faulting not committed", 32'(commit_valid), 0);
      chk("R6", "younger mem blocked", 32'(me_mem_en), 0);
      go(8);
      chk("R4", "handler fetch", fetch_pc, HPC);
      chk("R4", "priv set", 32'(priv_mode), 1);
      chk("R4", "epc", epc, RPC + 8);
      chk("R3", "mem code", 32'(cause), 32'h24);
      chk("R11", "flush dropped", 32'(flush), 0);
      go(9);
      id_eret = 1;
      go(10);
      id_eret = 0;
      go(12);
      chk("R9", "return commits", 32'(commit_valid), 1);
      chk("R9", "return pc", commit_pc, HPC);
      chk("R9", "return flush", 32'(flush), 1);
      go(13);
      chk("R9", "resume fetch", fetch_pc, RPC + 8);
      chk("R9", "priv cleared", 32'(priv_mode), 0);
      chk("R9", "no stale commit", 32'(commit_valid), 0);
      go(17);
      chk("R9", "retry commits", 32'(commit_valid), 1);
      chk("R9", "retry pc", commit_pc, RPC + 8);
   endtask

   // Younger decode fault raised first, older memory fault one cycle later
   task automatic t_order();
      do_reset();
      go(5);
      id_fault = 1;
      go(6);
      id_fault = 0;
      me_fault = 1;
      go(7);
      me_fault = 0;
      go(8);
      chk("R5", "older wins cause", 32'(cause), 32'h24);
      chk("R5", "older wins epc", epc, RPC + 8);
   endtask

   task automatic t_stage_codes();
      do_reset();
      go(2);
      if_fault = 1;
      go(3);
      if_fault = 0;
      go(7);
      chk("R3", "fetch code", 32'(cause), 32'h21);
      chk("R3", "fetch epc", epc, RPC + 4);
      do_reset();
      go(3);
      id_fault = 1;
      go(4);
      id_fault = 0;
      go(5);
      chk("R6", "older commits before decode fault", commit_pc, RPC);
      go(6);
      chk("R6", "decode faulter not committed", 32'(commit_valid), 0);
      go(7);
      chk("R3", "decode code", 32'(cause), 32'h22);
      do_reset();
      go(4);
      ex_fault = 1;
      go(5);
      ex_fault = 0;
      go(7);
      chk("R3", "execute code", 32'(cause), 32'h23);
      chk("R3", "execute epc", epc, RPC + 4);
   endtask

   task automatic t_irq();
      do_reset();
      go(6);
      irq_code = 5'h05;
      go(7);
      chk("R7", "interrupted mem blocked", 32'(me_mem_en), 0);
      chk("R7", "older completes", commit_pc, RPC + 8);
      chk("R7", "older commit valid", 32'(commit_valid), 1);
      go(8);
      chk("R7", "irq flush", 32'(flush), 1);
      go(9);
      chk("R7", "irq cause", 32'(cause), 32'h25);
      chk("R7", "irq epc", epc, RPC + 12);
      chk("R7", "irq priv", 32'(priv_mode), 1);
      for (int k = 10; k <= 14; k++) begin
         go(k);
         chk("R8", "masked in priv", 32'(flush), 0);
      end
      chk("R8", "handler keeps running", commit_pc, HPC + 4);
      irq_code = '0;
   endtask

   // Interrupt and older memory fault in the same cycle
   task automatic t_irq_vs_fault();
      do_reset();
      go(6);
      me_fault = 1;
      irq_code = 5'h03;
      go(7);
      me_fault = 0;
      chk("R8", "flush from fault", 32'(flush), 1);
      go(8);
      irq_code = '0;
      chk("R8", "fault code kept", 32'(cause), 32'h24);
      chk("R8", "fault epc kept", epc, RPC + 8);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_stream();
      t_mem_fault_and_return();
      t_order();
      t_stage_codes();
      t_irq();
      t_irq_vs_fault();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule